// File: doc/BRIEF.md
# Configurable UART Character Framer

This block is the character engine that sits between a UART's FIFOs and its serial pins. A 16x oversampling tick paces both directions. On the transmit side a byte taken over a valid/ready handshake is turned into a serial frame: a start bit, 5 to 8 data bits sent LSB first, an optional parity bit, then one or two stop bits. On the receive side the line is synchronised, a start bit is found and checked at mid-bit, and every later bit is sampled at the centre of its cell. The rebuilt character leaves on a valid/ready output as a 12-bit word that carries four error flags above the data byte.

A set of line-control inputs sets the frame shape: word length, parity on/off, parity select, stick parity and two stop bits. A break control holds the transmit pin low. The receiver reports a line held low for a whole frame as a break character. It marks a character with overrun when the previous one was still waiting downstream. Both directions capture the frame settings when a character starts, so a change to the settings in the middle of a frame takes effect on the next character.

Top module: `uart_char_engine`

## Requirements
- R1: The word-length code `cfg_wlen` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Data bits go out LSB first, and received data bits above the word length read as 0.
- R2: With `cfg_two_stop` = 1 a frame carries two stop bits, and with 0 it carries one. Each stop bit is a 1.
- R3: With `cfg_par_en` = 0 there is no parity bit. With `cfg_par_en` = 1 and `cfg_stick` = 0 a parity bit follows the data: `cfg_par_sel` = 1 gives even parity and 0 gives odd parity.
- R4: With `cfg_par_en` = 1 and `cfg_stick` = 1 the parity bit is a constant: 1 when `cfg_par_sel` = 0 and 0 when `cfg_par_sel` = 1.
- R5: The received word holds the data in bits [7:0], the framing flag in bit 8, the parity flag in bit 9, the break flag in bit 10 and the overrun flag in bit 11. `rx_valid` stays high until a cycle with `rx_ready` high.
- R6: `busy` goes high in the cycle after a byte is accepted and stays high until the last stop bit has lasted its full 16 ticks. `txd` is 1 while idle.
- R7: While `cfg_brk` = 1, `txd` is 0.
- R8: The receiver starts a character only on a high-to-low change of the line. A start bit that is high again when sampled at tick 8 is ignored and yields no word.
- R9: A line that stays low through the start bit, the data, the parity and the stop bits yields one word with data 0, the break and framing flags set and the parity flag clear (0x500). The receiver then waits for the line to go high before it looks for a new start bit.
- R10: A character that completes while the previous word is still held (`rx_valid` = 1 and `rx_ready` = 0) replaces that word and has the overrun flag set.
- R11: A received stop bit sampled as 0 sets the framing flag. A received parity bit that does not match the R3/R4 rule sets the parity flag.
- R12: `tx_ready` is 1 exactly when `busy` is 0, so a new byte is accepted only between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_wlen | input | 2 | Word-length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_sel | input | 1 | Parity select (1 = even, or 0 when stick) |
| cfg_stick | input | 1 | Stick parity |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_brk | input | 1 | Hold transmit line low |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | Character being shifted out |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | Received word available |
| rx_word | output | 12 | {overrun, break, parity err, framing err, data[7:0]} |
| rx_ready | input | 1 | Downstream takes the word |

## Verification
A wrong transmit bit counter shows up as a frame that is too long or too short, or as a shifted parity or stop bit. `busy` then falls at the wrong time, so the fault is visible on `txd` within one frame, at most 12 bit times. A wrong receive sample phase or an index that has slipped puts data bits into the wrong place or raises false framing or parity flags on the next word. A missing re-arm after a break or a glitch shows up as a lost word or an extra word. Each of these appears at `rx_valid` within one frame time, because the decode happens at the centre of the last stop bit.

// File: rtl/uce_pkg.sv
`timescale 1ns/1ps
package uce_pkg;

   localparam int DATA_MAX  = 8;
   localparam int WORD_W    = DATA_MAX + 4;
   localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
   localparam int AFTER_MAX = FRAME_MAX - 1;

   typedef struct packed {
      logic [1:0] wlen;
      logic       par_en;
      logic       par_sel;
      logic       stick;
      logic       two_stop;
   } line_cfg_t;

   function automatic int data_bits(logic [1:0] code);
      return 5 + int'(code);
   endfunction

   function automatic int bits_after_start(line_cfg_t c);
      return data_bits(c.wlen) + int'(c.par_en) + 1 + int'(c.two_stop);
   endfunction

   function automatic logic parity_of(line_cfg_t c, logic [DATA_MAX-1:0] d);
      logic x;
      x = 1'b0;
      for (int i = 0; i < DATA_MAX; i++)
         if (i < data_bits(c.wlen)) x = x ^ d[i];
      if (c.stick) return ~c.par_sel;
      return c.par_sel ? x : ~x;
   endfunction

   function automatic logic [FRAME_MAX-1:0] build_frame(line_cfg_t c, logic [DATA_MAX-1:0] d);
      logic [FRAME_MAX-1:0] f;
      int wl;
      wl = data_bits(c.wlen);
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < DATA_MAX; i++)
         if (i < wl) f[1+i] = d[i];
      if (c.par_en) f[1+wl] = parity_of(c, d);
      return f;
   endfunction

   // returns {break, parity_err, framing_err, data}
   function automatic logic [WORD_W-2:0] decode(line_cfg_t c, logic [AFTER_MAX-1:0] b);
      logic [DATA_MAX-1:0] d;
      logic fe, pe, brk;
      int wl, sp, n;
      wl  = data_bits(c.wlen);
      sp  = wl + int'(c.par_en);
      n   = bits_after_start(c);
      d   = '0;
      fe  = 1'b0;
      pe  = 1'b0;
      brk = 1'b1;
      for (int i = 0; i < DATA_MAX; i++)
         if (i < wl) d[i] = b[i];
      for (int i = 0; i < AFTER_MAX; i++)
         if (i < n && b[i]) brk = 1'b0;
      if (!b[sp]) fe = 1'b1;
      if (c.two_stop && !b[sp+1]) fe = 1'b1;
      if (c.par_en && (b[wl] != parity_of(c, d))) pe = 1'b1;
      if (brk) begin
         fe = 1'b1;
         pe = 1'b0;
      end
      return {brk, pe, fe, d};
   endfunction

endpackage

// File: rtl/uce_sync.sv
`timescale 1ns/1ps
module uce_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uce_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/uce_tx.sv
`timescale 1ns/1ps
module uce_tx
   import uce_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  line_cfg_t           cfg,
   input  logic                tx_valid,
   input  logic [DATA_MAX-1:0] tx_data,
   output logic                tx_ready,
   output logic                busy,
   output logic                line
);
   localparam int CNT_W = $clog2(OVS);
   localparam int LEN_W = $clog2(FRAME_MAX + 1);

   logic [FRAME_MAX-1:0] shreg;
   logic [LEN_W-1:0]     left;
   logic [CNT_W-1:0]     tcnt;
   logic                 accept;
   logic                 cell_end;

   assign tx_ready = ~busy;
   assign accept   = tx_valid & tx_ready;
   assign cell_end = busy & tick & (tcnt == CNT_W'(OVS-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         left  <= '0;
         tcnt  <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         shreg <= build_frame(cfg, tx_data);
         left  <= LEN_W'(1 + bits_after_start(cfg));
         tcnt  <= '0;
      end else if (busy && tick) begin
         if (cell_end) begin
            tcnt  <= '0;
            shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
            left  <= left - 1'b1;
            if (left == LEN_W'(1)) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assign line = busy ? shreg[0] : 1'b1;

   a_r12_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> busy);
   a_r6_busy_falls_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick));
   a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> line);
endmodule

// File: rtl/uce_rx.sv
`timescale 1ns/1ps
module uce_rx
   import uce_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  line_cfg_t         cfg,
   input  logic              line_s,
   output logic              rx_valid,
   output logic [WORD_W-1:0] rx_word,
   input  logic              rx_ready
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(AFTER_MAX + 1);
   localparam int MID   = OVS / 2;

   typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS} rx_state_t;

   rx_state_t            st;
   line_cfg_t            cfg_l;
   logic                 armed;
   logic [CNT_W-1:0]     cnt;
   logic [IDX_W-1:0]     idx;
   logic [IDX_W-1:0]     nbits;
   logic [AFTER_MAX-1:0] bits, bits_nx;
   logic                 sample;
   logic                 done;
   logic [WORD_W-2:0]    dec;
   logic                 in_start;

   assign nbits  = IDX_W'(bits_after_start(cfg_l));
   assign sample = tick & (st == ST_BITS) & (cnt == CNT_W'(OVS-1));
   assign done   = sample & (idx == nbits - 1'b1);

   always_comb begin
      bits_nx      = bits;
      bits_nx[idx] = line_s;
   end

   assign dec      = decode(cfg_l, bits_nx);
   assign in_start = (st == ST_START);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cfg_l <= '0;
         armed <= 1'b0;
         cnt   <= '0;
         idx   <= '0;
         bits  <= '0;
      end else if (tick) begin
         unique case (st)
            ST_IDLE: begin
               if (line_s) begin
                  armed <= 1'b1;
               end else if (armed) begin
                  st    <= ST_START;
                  cnt   <= '0;
                  cfg_l <= cfg;
                  armed <= 1'b0;
               end
            end
            ST_START: begin
               if (cnt == CNT_W'(MID-1)) begin
                  cnt  <= '0;
                  idx  <= '0;
                  bits <= '0;
                  st   <= line_s ? ST_IDLE : ST_BITS;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_BITS: begin
               if (sample) begin
                  cnt  <= '0;
                  bits <= bits_nx;
                  if (done) st  <= ST_IDLE;
                  else      idx <= idx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid <= 1'b0;
         rx_word  <= '0;
      end else if (done) begin
         rx_valid <= 1'b1;
         rx_word  <= {rx_valid & ~rx_ready, dec};
      end else if (rx_valid && rx_ready) begin
         rx_valid <= 1'b0;
      end
   end

   a_r5_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> rx_valid);
   a_r9_break_word_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_word[10]) |-> (rx_word[8] && !rx_word[9] && rx_word[7:0] == '0));
   a_r8_start_from_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_start) |-> !$past(line_s));
   a_r10_overrun_when_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && done) |=> rx_word[11]);
endmodule

// File: rtl/uart_char_engine.sv
`timescale 1ns/1ps
module uart_char_engine
   import uce_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_sel,
   input  logic              cfg_stick,
   input  logic              cfg_two_stop,
   input  logic              cfg_brk,
   input  logic              tx_valid,
   input  logic [7:0]        tx_data,
   output logic              tx_ready,
   output logic              txd,
   output logic              busy,
   input  logic              rxd,
   output logic              rx_valid,
   output logic [11:0]       rx_word,
   input  logic              rx_ready
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uart_char_engine: OVS must be even and at least 4");
      end
   endgenerate

   line_cfg_t cfg;
   logic      tx_line;
   logic      rx_line;

   assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en, par_sel: cfg_par_sel,
                  stick: cfg_stick, two_stop: cfg_two_stop};

   uce_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .busy(busy), .line(tx_line)
   );

   uce_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_line)
   );

   uce_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .line_s(rx_line),
      .rx_valid(rx_valid), .rx_word(rx_word), .rx_ready(rx_ready)
   );

   assign txd = cfg_brk ? 1'b0 : tx_line;

   a_r7_break_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_brk |-> !txd);
   a_r12_ready_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready != busy);
endmodule

// File: tb/uart_char_engine_tb.sv
`timescale 1ns/1ps
module uart_char_engine_tb;
   localparam int BITCLK = 32;   // 16 ticks, one tick every 2 clocks

   logic        clk = 0, rst_n = 0, tick = 0;
   logic [1:0]  cfg_wlen = 2'd3;
   logic        cfg_par_en = 0, cfg_par_sel = 0, cfg_stick = 0, cfg_two_stop = 0, cfg_brk = 0;
   logic        tx_valid = 0;
   logic [7:0]  tx_data = 0;
   logic        tx_ready, txd, busy, rx_valid, rx_ready = 1, rxd = 1;
   logic [11:0] rx_word;

   int nchk = 0, nfail = 0, got_cnt = 0;
   logic [11:0] got_word = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   uart_char_engine u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
      .cfg_par_sel(cfg_par_sel), .cfg_stick(cfg_stick), .cfg_two_stop(cfg_two_stop),
      .cfg_brk(cfg_brk), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .txd(txd), .busy(busy), .rxd(rxd), .rx_valid(rx_valid), .rx_word(rx_word),
      .rx_ready(rx_ready)
   );

   initial forever begin
      @(posedge clk); #1 tick = ~tick;
   end

   always @(negedge clk) if (rx_valid && rx_ready) begin
      got_word = rx_word;
      got_cnt++;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   function automatic logic bpar(int wl, bit ps, bit sp, logic [7:0] d);
      int ones = 0;
      for (int i = 0; i < wl; i++) ones += int'(d[i]);
      if (sp) return !ps;
      return ps ? logic'(ones % 2) : logic'(!(ones % 2));
   endfunction

   // frame bits, start first, and count
   function automatic void mk(input logic [7:0] d, output logic [11:0] f, output int n);
      int wl = 5 + int'(cfg_wlen);
      int p;
      f = '1; f[0] = 0;
      for (int i = 0; i < wl; i++) f[1+i] = d[i];
      p = 1 + wl;
      if (cfg_par_en) begin f[p] = bpar(wl, cfg_par_sel, cfg_stick, d); p++; end
      n = p + 1 + int'(cfg_two_stop);
   endfunction

   task automatic send_bits(input logic [11:0] f, input int n);
      for (int i = 0; i < n; i++) begin rxd = f[i]; wclk(BITCLK); end
      rxd = 1; wclk(BITCLK);
   endtask

   task automatic tx_case(input logic [7:0] d, input string tag);
      logic [11:0] f, cap; int n, t;
      mk(d, f, n);
      cap = '1;
      tx_valid = 1; tx_data = d;
      t = 0;
      while (!tx_ready && t < 2000) begin @(negedge clk); t++; end
      @(posedge clk); #1 tx_valid = 0;
      t = 0;
      @(negedge clk);
      while (txd && t < 200) begin @(negedge clk); t++; end
      repeat (16) @(negedge clk);
      cap[0] = txd;
      for (int i = 1; i < n; i++) begin
         repeat (BITCLK) @(negedge clk);
         cap[i] = txd;
         if (i == n - 1) chk(busy && !tx_ready, "R6/R12 busy during last stop", {busy, tx_ready}, 2'b10);
      end
      for (int i = n; i < 12; i++) cap[i] = 1'b1;
      chk(cap == f, tag, cap, f);
      repeat (20) @(negedge clk);
      chk(!busy && txd && tx_ready, "R6 idle after frame", {busy, txd, tx_ready}, 3'b011);
   endtask

   task automatic rx_case(input logic [7:0] d, input bit bad_par, input bit bad_stop, input string tag);
      logic [11:0] f; int n, wl, prev; logic [11:0] exp; logic [7:0] dm;
      mk(d, f, n);
      wl = 5 + int'(cfg_wlen);
      if (bad_par && cfg_par_en) f[1+wl] = ~f[1+wl];
      if (bad_stop) f[1+wl+int'(cfg_par_en)] = 1'b0;
      dm = '0;
      for (int i = 0; i < wl; i++) dm[i] = d[i];
      exp = {4'b0, dm};
      if (bad_par && cfg_par_en) exp[9] = 1;
      if (bad_stop) exp[8] = 1;
      if ((f & ((12'd1 << n) - 1)) == 0) exp = 12'h500;
      prev = got_cnt;
      send_bits(f, n);
      chk(got_cnt == prev + 1, {tag, " count"}, got_cnt - prev, 1);
      chk(got_word == exp, tag, got_word, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nfail++; nchk++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int prev;
      logic [7:0] d;
      void'($urandom(32'h1234_abcd));
      wclk(5); rst_n = 1; wclk(2);
      @(negedge clk);
      chk(txd && !busy && tx_ready && !rx_valid, "reset R6/R12", {txd, busy, tx_ready, rx_valid}, 4'b1010);
      wclk(1);

      // directed: each word length, no parity, one stop (R1)
      for (int w = 0; w < 4; w++) begin
         cfg_wlen = 2'(w);
         tx_case(8'hA7, "R1 tx word length");
         rx_case(8'hD6, 0, 0, "R1 rx word length/R5 layout");
      end
      // two stop bits (R2)
      cfg_wlen = 3; cfg_two_stop = 1;
      tx_case(8'h3C, "R2 tx two stops");
      rx_case(8'h3C, 0, 0, "R2 rx two stops");
      // even / odd (R3)
      cfg_two_stop = 0; cfg_par_en = 1; cfg_par_sel = 1;
      tx_case(8'h07, "R3 tx even parity");
      rx_case(8'h07, 1, 0, "R11 rx parity error even");
      cfg_par_sel = 0;
      tx_case(8'h07, "R3 tx odd parity");
      rx_case(8'h07, 0, 0, "R3 rx odd parity ok");
      // stick (R4)
      cfg_stick = 1; cfg_par_sel = 0;
      tx_case(8'h00, "R4 tx mark parity");
      rx_case(8'h00, 0, 0, "R4 rx mark parity ok");
      cfg_par_sel = 1;
      tx_case(8'hFF, "R4 tx space parity");
      rx_case(8'hFF, 1, 0, "R4 rx space parity error");
      cfg_stick = 0; cfg_par_en = 0;
      // framing error (R11)
      rx_case(8'h5A, 0, 1, "R11 rx framing error");

      // break transmit (R7)
      @(posedge clk); #1 cfg_brk = 1;
      @(negedge clk);
      chk(!txd, "R7 break low", txd, 0);
      @(posedge clk); #1 cfg_brk = 0;
      @(negedge clk);
      chk(txd, "R7 break released", txd, 1);

      // glitch (R8)
      prev = got_cnt;
      rxd = 0; wclk(4); rxd = 1; wclk(BITCLK * 14);
      chk(got_cnt == prev, "R8 glitch ignored", got_cnt - prev, 0);
      rx_case(8'h81, 0, 0, "R8 frame after glitch");

      // break detect (R9)
      prev = got_cnt;
      rxd = 0; wclk(BITCLK * 14);
      chk(got_cnt == prev + 1 && got_word == 12'h500, "R9 break word", got_word, 12'h500);
      wclk(BITCLK * 4);
      chk(got_cnt == prev + 1, "R9 single break word", got_cnt - prev, 1);
      rxd = 1; wclk(BITCLK);
      rx_case(8'h42, 0, 0, "R9 frame after break");

      // overrun (R10)
      @(posedge clk); #1 rx_ready = 0;
      begin
         logic [11:0] f; int n;
         mk(8'h11, f, n); send_bits(f, n);
         chk(rx_valid && rx_word == 12'h011, "R5 held word", rx_word, 12'h011);
         mk(8'h22, f, n); send_bits(f, n);
      end
      prev = got_cnt;
      @(posedge clk); #1 rx_ready = 1;
      wclk(2);
      chk(got_cnt == prev + 1 && got_word == 12'h822, "R10 overrun flag", got_word, 12'h822);
      rx_case(8'h33, 0, 0, "R10 no overrun after drain");

      // constrained random
      for (int k = 0; k < 24; k++) begin
         cfg_wlen = 2'($urandom_range(0, 3));
         cfg_par_en = 1'($urandom_range(0, 1));
         cfg_par_sel = 1'($urandom_range(0, 1));
         cfg_stick = 1'($urandom_range(0, 1));
         cfg_two_stop = 1'($urandom_range(0, 1));
         d = 8'($urandom);
         tx_case(d, "R1-random tx frame R3");
         rx_case(8'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) == 0),
                 "R5 random rx word R11");
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule